// File: doc/BRIEF.md
# Power-Good Window Monitor with Qualification Delay

This block decides when a buck regulator controller may report its output as good. Every clock cycle it takes a digitized output-voltage code and the current target code, and checks the sample against an asymmetric window whose edges are set as percentages of the target. The percentages are in tenths of a percent. The window follows the target, so it stays valid during margining or tracking. A global fault flag and a soft-start completion flag also gate the result. The output rises only after every condition has held for a programmable number of clock cycles.

Deassertion is immediate. In the first cycle in which any condition fails, the output drops. An over-voltage excursion is one such failure. A small parallel write port sets the upper limit, the lower limit and the delay. An analog front end and a host-bus bridge sit outside the block.

Top module: `pgood_window_mon`

## Requirements
- R1: While `rst` is high, `pgood` is driven low after the next rising edge. Reset loads an upper limit of 150 (+15.0%), a lower limit of 100 (-10.0%) and a delay of `DLY_DEF` cycles (default 50000, which is 1 ms at 50 MHz).
- R2: The sample is in the window when `vout_code*1000 <= vtarget_code*(1000+up)` and `vout_code*1000 >= vtarget_code*(1000-lo)`. Both bounds are inclusive, and `up` and `lo` are in units of 0.1%.
- R3: A cycle with `fault_any` high forces `pgood` low after that edge, and restarts qualification.
- R4: A cycle with `ss_done` low forces `pgood` low after that edge, and restarts qualification.
- R5: With a delay value D, `pgood` rises after the (D+1)-th consecutive rising edge at which all conditions hold. D = 0 asserts at the first such edge.
- R6: Any edge at which a condition fails while the delay is still counting restarts the count from zero.
- R7: Once `pgood` is high, the first edge at which the sample leaves the window, over-voltage included, drops `pgood` after that same edge.
- R8: A write with `cfg_we` high takes effect at the rising edge. Address 0 sets the upper limit from `cfg_wdata[9:0]`. Address 1 sets the lower limit from `cfg_wdata[9:0]`. Address 2 sets the 32-bit delay. Writes to address 3 change nothing.
- R9: A lower-limit value above 1000 acts as exactly 1000, which puts the lower bound at zero.
- R10: The window bounds follow `vtarget_code` in every cycle, so a change of target can move a fixed sample out of the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vout_code | input | VW (12) | Digitized output voltage sample |
| vtarget_code | input | VW (12) | Current target voltage code |
| fault_any | input | 1 | High while any fault is active |
| ss_done | input | 1 | High once the soft-start ramp has finished |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | DLY_W (32) | Register write data |
| pgood | output | 1 | Registered power-good output |

## Verification
Every failing condition (out of window, fault, soft-start not done) shows on `pgood` one rising edge after the inputs present it. A qualifying run shows after exactly D+1 edges. Register writes are in force from the edge that captures them. The bench changes inputs on falling edges and reads `pgood` on a later falling edge, after counting the exact number of rising edges that has passed. It checks the delay both at D edges, where `pgood` must still be low, and at D+1 edges, where it must be high. With the delay set to zero, each random stimulus is due one edge later.

// File: rtl/pgood_pkg.sv
package pgood_pkg;

  typedef enum logic [1:0] {
    CFG_UP_PCT = 2'd0,
    CFG_LO_PCT = 2'd1,
    CFG_DELAY  = 2'd2,
    CFG_SPARE  = 2'd3
  } cfg_sel_e;

  localparam int unsigned PCT_FULL_SCALE = 1000;

endpackage

// File: rtl/pgood_cfg_regs.sv
module pgood_cfg_regs
  import pgood_pkg::*;
#(
  parameter int PCT_W   = 10,
  parameter int DLY_W   = 32,
  parameter int UP_DEF  = 150,
  parameter int LO_DEF  = 100,
  parameter int DLY_DEF = 50000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [DLY_W-1:0] wdata,
  output logic [PCT_W-1:0] up_pct,
  output logic [PCT_W-1:0] lo_pct,
  output logic [DLY_W-1:0] dly_val
);

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      up_pct  <= PCT_W'(UP_DEF);
      lo_pct  <= PCT_W'(LO_DEF);
      dly_val <= DLY_W'(DLY_DEF);
    end else if (we) begin
      case (sel)
        CFG_UP_PCT: up_pct  <= wdata[PCT_W-1:0];
        CFG_LO_PCT: lo_pct  <= wdata[PCT_W-1:0];
        CFG_DELAY:  dly_val <= wdata;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/pgood_window_cmp.sv
module pgood_window_cmp
  import pgood_pkg::*;
#(
  parameter int VW    = 12,
  parameter int PCT_W = 10
) (
  input  logic [VW-1:0]    sample,
  input  logic [VW-1:0]    target,
  input  logic [PCT_W-1:0] up_pct,
  input  logic [PCT_W-1:0] lo_pct,
  output logic             in_win
);

  localparam int FW = PCT_W + 2;
  localparam int PW = VW + FW;
  localparam logic [FW-1:0] FULL_F = FW'(PCT_FULL_SCALE);

  logic [FW-1:0] up_fac;
  logic [FW-1:0] lo_fac;
  logic [FW-1:0] lo_eff;
  logic [PW-1:0] scaled_sample;
  logic [PW-1:0] hi_bound;
  logic [PW-1:0] lo_bound;
  logic          below_hi;
  logic          above_lo;

  always_comb begin
    // lower percentage saturates at full scale so the bound cannot wrap
    lo_eff = (FW'(lo_pct) > FULL_F) ? FULL_F : FW'(lo_pct);
    up_fac = FULL_F + FW'(up_pct);
    lo_fac = FULL_F - lo_eff;
  end

  // scaling both sides avoids a divider: compare sample*1000 to target*factor
  assign scaled_sample = PW'(sample) * PW'(FULL_F);
  assign hi_bound      = PW'(target) * PW'(up_fac);
  assign lo_bound      = PW'(target) * PW'(lo_fac);

  assign below_hi = (scaled_sample <= hi_bound);
  assign above_lo = (scaled_sample >= lo_bound);
  assign in_win   = below_hi & above_lo;

endmodule

// File: rtl/pgood_qualifier.sv
module pgood_qualifier #(
  parameter int DLY_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_win,
  input  logic             fault_any,
  input  logic             ss_done,
  input  logic [DLY_W-1:0] dly_val,
  output logic             pgood
);

  logic             all_ok;
  logic [DLY_W-1:0] run_cnt;

  assign all_ok = in_win & ~fault_any & ss_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      pgood   <= 1'b0;
    end else if (!all_ok) begin
      run_cnt <= '0;
      pgood   <= 1'b0;
    end else if (run_cnt >= dly_val) begin
      pgood   <= 1'b1;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pgood_window_mon.sv
module pgood_window_mon #(
  parameter int VW      = 12,
  parameter int PCT_W   = 10,
  parameter int DLY_W   = 32,
  parameter int UP_DEF  = 150,
  parameter int LO_DEF  = 100,
  parameter int DLY_DEF = 50000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VW-1:0]    vout_code,
  input  logic [VW-1:0]    vtarget_code,
  input  logic             fault_any,
  input  logic             ss_done,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [DLY_W-1:0] cfg_wdata,
  output logic             pgood
);

  logic [PCT_W-1:0] up_pct;
  logic [PCT_W-1:0] lo_pct;
  logic [DLY_W-1:0] dly_val;
  logic             in_win;

  pgood_cfg_regs #(
    .PCT_W(PCT_W), .DLY_W(DLY_W),
    .UP_DEF(UP_DEF), .LO_DEF(LO_DEF), .DLY_DEF(DLY_DEF)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .up_pct(up_pct), .lo_pct(lo_pct), .dly_val(dly_val)
  );

  pgood_window_cmp #(.VW(VW), .PCT_W(PCT_W)) u_cmp (
    .sample(vout_code), .target(vtarget_code),
    .up_pct(up_pct), .lo_pct(lo_pct), .in_win(in_win)
  );

  pgood_qualifier #(.DLY_W(DLY_W)) u_qual (
    .clk(clk), .rst(rst), .in_win(in_win), .fault_any(fault_any),
    .ss_done(ss_done), .dly_val(dly_val), .pgood(pgood)
  );

endmodule

// File: rtl/pgood_window_mon_chk.sv
module pgood_window_mon_chk #(
  parameter int DLY_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             fault_any,
  input logic             ss_done,
  input logic             pgood,
  input logic [DLY_W-1:0] dly_val
);

  logic [DLY_W:0] gate_run;

  // consecutive edges with fault clear and soft-start done
  always_ff @(posedge clk) begin
    if (rst || fault_any || !ss_done) gate_run <= '0;
    else if (gate_run != '1)          gate_run <= gate_run + 1'b1;
  end

  // R1: reset drives the output low
  a_r1_reset_low: assert property (@(posedge clk) rst |=> !pgood);

  // R3: a fault clears the output on the next edge
  a_r3_fault_clears: assert property (@(posedge clk) disable iff (rst)
    fault_any |=> !pgood);

  // R4: no power-good before soft-start completes
  a_r4_ss_gates: assert property (@(posedge clk) disable iff (rst)
    !ss_done |=> !pgood);

  // R5: a rising output needs at least D+1 gated edges
  a_r5_delay_met: assert property (@(posedge clk) disable iff (rst)
    $rose(pgood) |-> (gate_run >= ({1'b0, $past(dly_val)} + 1'b1)));

  // R6: a rise is preceded by a clean gate on the prior edge
  a_r6_clean_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(pgood) |-> (gate_run != '0));

endmodule

bind pgood_window_mon pgood_window_mon_chk #(.DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst(rst), .fault_any(fault_any), .ss_done(ss_done),
  .pgood(pgood), .dly_val(dly_val)
);

// File: tb/test_pgood_window_mon.sv
`timescale 1ns/1ps
module test_pgood_window_mon;

  localparam int VW = 12;
  localparam int DLY_W = 32;
  localparam int DLY_DEF = 50000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [VW-1:0]    vout_code = '0;
  logic [VW-1:0]    vtarget_code = '0;
  logic             fault_any = 1'b0;
  logic             ss_done = 1'b0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_addr = '0;
  logic [DLY_W-1:0] cfg_wdata = '0;
  logic             pgood;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pgood_window_mon #(.DLY_DEF(DLY_DEF)) i_pgood_window_mon (
    .clk(clk), .rst(rst), .vout_code(vout_code), .vtarget_code(vtarget_code),
    .fault_any(fault_any), .ss_done(ss_done), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pgood(pgood)
  );

  function automatic bit exp_win(int s, int t, int up, int lo);
    longint a = longint'(s) * 1000;
    int le = (lo > 1000) ? 1000 : lo;
    return (a <= longint'(t) * (1000 + up)) && (a >= longint'(t) * (1000 - le));
  endfunction

  task automatic check(bit act, bit exp, string req, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(int s, int t, bit f, bit ss);
    vout_code = VW'(s); vtarget_code = VW'(t); fault_any = f; ss_done = ss;
  endtask

  // drive at a falling edge, wait n rising edges, sample at the falling edge
  task automatic apply(int s, int t, bit f, bit ss, int n);
    @(negedge clk);
    drive(s, t, f, ss);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=done");
    report();
  end

  initial begin
    int up_c, lo_c;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    check(pgood, 1'b0, "R1", "pgood in reset");
    drive(1000, 1000, 1'b0, 1'b1);
    @(negedge clk); rst = 1'b0;

    // R1/R5: default delay of DLY_DEF cycles with in-window input
    repeat (DLY_DEF) @(negedge clk);
    check(pgood, 1'b0, "R5", "default delay not yet elapsed");
    @(negedge clk);
    check(pgood, 1'b1, "R1", "default delay elapsed");

    // R7: over-voltage drops immediately
    apply(1151, 1000, 1'b0, 1'b1, 1);
    check(pgood, 1'b0, "R7", "overvoltage drop");

    wr(2, 32'd0);
    // R2 boundaries with default limits
    apply(1150, 1000, 1'b0, 1'b1, 1); check(pgood, 1'b1, "R2", "upper edge 1150 in");
    apply(1151, 1000, 1'b0, 1'b1, 1); check(pgood, 1'b0, "R2", "1151 out");
    apply(900, 1000, 1'b0, 1'b1, 1);  check(pgood, 1'b1, "R2", "lower edge 900 in");
    apply(899, 1000, 1'b0, 1'b1, 1);  check(pgood, 1'b0, "R2", "899 out");
    apply(1000, 1000, 1'b1, 1'b1, 1); check(pgood, 1'b0, "R3", "fault gates");
    apply(1000, 1000, 1'b0, 1'b0, 1); check(pgood, 1'b0, "R4", "soft-start gates");
    apply(1000, 1000, 1'b0, 1'b1, 1); check(pgood, 1'b1, "R5", "zero delay next edge");

    // R10: target moves, sample fixed
    apply(1000, 800, 1'b0, 1'b1, 1);  check(pgood, 1'b0, "R10", "target lowered");
    apply(1000, 1100, 1'b0, 1'b1, 1); check(pgood, 1'b1, "R10", "target raised");

    // R8: spare address ignored, pct field takes low bits
    wr(3, 32'd0);
    apply(1150, 1000, 1'b0, 1'b1, 1); check(pgood, 1'b1, "R8", "spare write ignored");
    wr(0, 32'hABCD_0000 | 32'd50);
    apply(1051, 1000, 1'b0, 1'b1, 1); check(pgood, 1'b0, "R8", "upper 5.0% 1051 out");
    apply(1050, 1000, 1'b0, 1'b1, 1); check(pgood, 1'b1, "R8", "upper 5.0% 1050 in");
    wr(1, 32'd1023);
    apply(0, 1000, 1'b0, 1'b1, 1);    check(pgood, 1'b1, "R9", "lower clamp zero in");
    wr(1, 32'd100);
    wr(0, 32'd150);

    // R5/R6: delay of 5
    apply(0, 1000, 1'b0, 1'b1, 1);
    wr(2, 32'd5);
    apply(1000, 1000, 1'b0, 1'b1, 5); check(pgood, 1'b0, "R5", "D edges low");
    @(negedge clk);                   check(pgood, 1'b1, "R5", "D+1 edges high");
    apply(1000, 1000, 1'b1, 1'b1, 1);
    apply(1000, 1000, 1'b0, 1'b1, 3);
    apply(1000, 1000, 1'b1, 1'b1, 1); check(pgood, 1'b0, "R6", "interrupted");
    apply(1000, 1000, 1'b0, 1'b1, 5); check(pgood, 1'b0, "R6", "count restarted");
    @(negedge clk);                   check(pgood, 1'b1, "R6", "full run after restart");

    // random window checks with zero delay
    wr(2, 32'd0);
    for (int i = 0; i < 300; i++) begin
      int t, s; bit f, ss;
      if (i % 20 == 0) begin
        up_c = $urandom_range(0, 1023);
        lo_c = $urandom_range(0, 1023);
        wr(0, 32'(up_c));
        wr(1, 32'(lo_c));
      end
      t = $urandom_range(0, 3000);
      s = $urandom_range(0, 4095);
      if ($urandom_range(0, 1) == 1) s = t + $urandom_range(0, 200) - 100;
      if (s < 0) s = 0;
      if (s > 4095) s = 4095;
      f = ($urandom_range(0, 7) == 0);
      ss = ($urandom_range(0, 7) != 0);
      apply(s, t, f, ss, 1);
      check(pgood, exp_win(s, t, up_c, lo_c) && !f && ss, "R2", "random window");
    end

    // R1: reset mid-operation
    @(negedge clk); rst = 1'b1;
    @(negedge clk); check(pgood, 1'b0, "R1", "reset clears");
    rst = 1'b0;
    report();
  end

endmodule